// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block holds the digital side of a 10-bit successive-approximation analog-to-digital converter in a small microcontroller. Software programs it through a byte-wide register port. One register holds the result layout, the reference choice, the channel, the start/busy bit and the module enable. A second register holds the conversion-clock choice and the per-pin analog enables. Two registers return the result, and two more hold the completion flag and its interrupt enable. Once started, the controller walks a trial code on `dac_code` from the most significant bit down, one bit per conversion-clock tick. It keeps or drops each bit according to the 1-bit comparator decision `cmp_in`.

The conversion clock is either the main clock divided by a power of two or a free-running internal RC tick supplied as `rc_tick`. Low-power sleep changes what happens. With the RC tick, the start waits for one instruction strobe and then carries on through sleep. At the end it raises a wakeup pulse if the interrupt is enabled, or powers the analog part down if it is not. With a divided clock, sleep stops the divider and aborts the conversion. In every case the enable bit keeps the value software wrote. The result registers have no reset and survive a device reset.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the clock register (address 1) reads 0x0F, the flag register (address 4) and enable register (address 5) read 0x00, and `wake_req` and `analog_on` are low.
- R2: A conversion runs ten steps, MSB first. While step k is in progress, `dac_code` equals the bits already kept plus bit k, so the first step shows 0x200. Each bit is kept when `cmp_in` is high at its tick. With a comparator that reports input >= `dac_code`, the result equals the input.
- R3: Control bit 7 selects the result layout. With 0 (left), address 2 reads result[9:2] and address 3 reads {result[1:0], 000000}. With 1 (right), address 2 reads {000000, result[9:8]} and address 3 reads result[7:0].
- R4: Control bits 5:4 always read 0. Bit 6 drives `ref_sel`, bits 3:2 drive `chan_sel`, bit 1 reads 1 while a conversion is pending or running, and bit 0 is the enable.
- R5: On completion, control bit 1 clears, the new result is stored and bit 6 of the flag register sets. Writing 0 to that bit clears it.
- R6: Clock register bits 6:4 select the conversion clock: a value n of 0 to 5 divides the main clock by 2^(n+1), and 6 or 7 selects `rc_tick`. A divided-clock conversion lasts between 9 and 10 periods of the divided clock after the start write.
- R7: With the RC clock selected, a started conversion makes no progress until an `instr_tick` pulse arrives, whatever `rc_tick` does. It then completes after ten `rc_tick` pulses.
- R8: An RC-clocked conversion that completes during `sleep` gives a one-cycle `wake_req` pulse if enable-register bit 6 is set. If that bit is clear, `analog_on` is low until `sleep` falls, while control bit 0 still reads 1.
- R9: When `sleep` is high and a divided clock is selected, any conversion stops within one cycle. Control bit 1 clears, no flag is set, the result registers keep their value, and `analog_on` is low until `sleep` falls, while control bit 0 still reads 1.
- R10: Writing control bit 1 with bit 0 clear in the same write starts nothing. Bit 1 reads 0, no flag sets and the result is unchanged.
- R11: Reset during a conversion aborts it and returns the control and clock registers to their reset values. The stored 10-bit result is kept.
- R12: Clock register bits 3:0 drive `pin_analog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| instr_tick | input | 1 | One-cycle strobe per instruction cycle |
| rc_tick | input | 1 | One-cycle strobe per internal RC clock period |
| sleep | input | 1 | Core is in low-power sleep |
| cmp_in | input | 1 | Comparator decision: input at or above `dac_code` |
| dac_code | output | 10 | Trial code for the comparison DAC |
| chan_sel | output | 2 | Analog channel select |
| ref_sel | output | 1 | Reference select |
| pin_analog | output | 4 | Per-pin analog enables |
| analog_on | output | 1 | Analog section powered |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
The hardest states to reach from the ports are the ones where `sleep` meets a conversion part way through. One case is a divided-clock conversion that must be cut off after several steps. The other is an RC conversion that must finish while the core sleeps, once with the interrupt enabled and once without. To get there, the bench runs free `rc_tick` and `instr_tick` generators. It starts a conversion, lets it run for a set number of cycles, then raises `sleep` and stops the instruction strobe. It then checks the busy bit, flag, result, `wake_req` and `analog_on`. It also withholds the instruction strobe while RC ticks keep running, to show that the RC start waits for it.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_CLK  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_RHI  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_RLO  = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd5;

   localparam int B_FMT  = 7;
   localparam int B_VREF = 6;
   localparam int B_CHAN = 2;
   localparam int B_GO   = 1;
   localparam int B_EN   = 0;
   localparam int B_SEL  = 4;
   localparam int B_AN   = 0;
   localparam int B_DONE = 6;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_RUN  = 2'd2
   } conv_state_t;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
   parameter int NUM_DIV = 6,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   input  logic             rc_tick,
   output logic             tick,
   output logic             rc_mode
);
   localparam int NSEL = 2 ** SEL_W;

   if (NUM_DIV < 1 || NUM_DIV >= NSEL) begin : g_bad_div
      $error("sar_tick_gen: NUM_DIV must leave at least one select code for the RC tick");
   end

   logic [NUM_DIV-1:0] cnt_q;
   logic [NSEL-1:0]    div_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_div
      if (i < NUM_DIV) begin : g_real
         assign div_hit[i] = run && (&cnt_q[i:0]);
      end else begin : g_rc
         assign div_hit[i] = 1'b0;
      end
   end

   assign rc_mode = (sel >= SEL_W'(NUM_DIV));

   always_comb tick = rc_mode ? rc_tick : div_hit[sel];

   a_r6_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !rc_mode) |-> !tick);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             tick,
   input  logic             cmp_in,
   output logic             busy,
   output logic             fin,
   output logic [RES_W-1:0] res_val,
   output logic [RES_W-1:0] dac_code
);
   logic [RES_W-1:0] approx_q;
   logic [RES_W-1:0] mask_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         approx_q <= '0;
         mask_q   <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         mask_q <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         approx_q <= '0;
         mask_q   <= {1'b1, {(RES_W-1){1'b0}}};
      end else if (busy_q && tick) begin
         if (cmp_in) approx_q <= approx_q | mask_q;
         mask_q <= mask_q >> 1;
         if (mask_q[0]) busy_q <= 1'b0;
      end
   end

   assign busy     = busy_q;
   assign fin      = busy_q && tick && mask_q[0] && !abort && !start;
   assign res_val  = approx_q | (cmp_in ? mask_q : '0);
   assign dac_code = busy_q ? (approx_q | mask_q) : '0;

   a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> $onehot(mask_q));
   a_r2_low_bits_open: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((approx_q & (mask_q | (mask_q - 1'b1))) == '0));
endmodule

// File: rtl/sar_justify.sv
module sar_justify #(
   parameter int RES_W  = 10,
   parameter int DATA_W = 8
) (
   input  logic [RES_W-1:0]  res,
   input  logic              right,
   output logic [DATA_W-1:0] hi,
   output logic [DATA_W-1:0] lo
);
   localparam int LO_W = RES_W - DATA_W;

   if (LO_W < 1 || LO_W >= DATA_W) begin : g_bad_w
      $error("sar_justify: RES_W must lie strictly between DATA_W and 2*DATA_W");
   end

   always_comb begin
      if (right) begin
         hi = DATA_W'(res[RES_W-1:DATA_W]);
         lo = res[DATA_W-1:0];
      end else begin
         hi = res[RES_W-1 -: DATA_W];
         lo = {res[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
      end
   end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_pkg::*;
#(
   parameter int RES_W   = 10,
   parameter int DATA_W  = 8,
   parameter int NUM_DIV = 6,
   parameter int SEL_W   = 3,
   parameter int CHAN_W  = 2,
   parameter int NUM_AN  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              instr_tick,
   input  logic              rc_tick,
   input  logic              sleep,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic [CHAN_W-1:0] chan_sel,
   output logic              ref_sel,
   output logic [NUM_AN-1:0] pin_analog,
   output logic              analog_on,
   output logic              wake_req
);
   if (DATA_W < 8 || CHAN_W > 2 || CHAN_W < 1 || SEL_W > 3 || NUM_AN > 4) begin : g_bad_layout
      $error("sar_conv_ctrl: field widths do not fit the byte-wide register layout");
   end

   logic              fmt_q, vref_q, adon_q, flag_q, ie_q, off_q, wake_q;
   logic [CHAN_W-1:0] chan_q;
   logic [SEL_W-1:0]  sel_q;
   logic [NUM_AN-1:0] an_q;
   logic [RES_W-1:0]  res_q;
   conv_state_t       state_q;

   logic tick, rc_mode, eng_busy, eng_fin, eng_start, kill, go_req;
   logic ctrl_wr, clk_wr, flag_wr, ien_wr, sleep_off;
   logic [RES_W-1:0]  eng_res;
   logic [DATA_W-1:0] res_hi, res_lo;

   assign ctrl_wr   = reg_wr && (reg_addr == ADR_CTRL);
   assign clk_wr    = reg_wr && (reg_addr == ADR_CLK);
   assign flag_wr   = reg_wr && (reg_addr == ADR_FLAG);
   assign ien_wr    = reg_wr && (reg_addr == ADR_IEN);
   assign sleep_off = sleep && !rc_mode;

   assign kill   = sleep_off || (ctrl_wr && !reg_wdata[B_EN]);
   assign go_req = ctrl_wr && reg_wdata[B_GO] && reg_wdata[B_EN] &&
                   (state_q == ST_IDLE) && !sleep_off;
   assign eng_start = !kill &&
                      ((go_req && !rc_mode) || (state_q == ST_HOLD && instr_tick));

   sar_tick_gen #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(!sleep), .sel(sel_q),
      .rc_tick(rc_tick), .tick(tick), .rc_mode(rc_mode)
   );

   sar_engine #(.RES_W(RES_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .abort(kill),
      .tick(tick), .cmp_in(cmp_in), .busy(eng_busy), .fin(eng_fin),
      .res_val(eng_res), .dac_code(dac_code)
   );

   sar_justify #(.RES_W(RES_W), .DATA_W(DATA_W)) u_just (
      .res(res_q), .right(fmt_q), .hi(res_hi), .lo(res_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q  <= 1'b0;
         vref_q <= 1'b0;
         chan_q <= '0;
         adon_q <= 1'b0;
         sel_q  <= '0;
         an_q   <= '1;
         ie_q   <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            fmt_q  <= reg_wdata[B_FMT];
            vref_q <= reg_wdata[B_VREF];
            chan_q <= reg_wdata[B_CHAN +: CHAN_W];
            adon_q <= reg_wdata[B_EN];
         end
         if (clk_wr) begin
            sel_q <= reg_wdata[B_SEL +: SEL_W];
            an_q  <= reg_wdata[B_AN +: NUM_AN];
         end
         if (ien_wr) ie_q <= reg_wdata[B_DONE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (kill) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (go_req) state_q <= rc_mode ? ST_HOLD : ST_RUN;
            ST_HOLD: if (instr_tick) state_q <= ST_RUN;
            ST_RUN:  if (eng_fin) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         wake_q <= 1'b0;
         off_q  <= 1'b0;
      end else begin
         if (eng_fin)      flag_q <= 1'b1;
         else if (flag_wr) flag_q <= reg_wdata[B_DONE];
         wake_q <= eng_fin && sleep && ie_q;
         off_q  <= sleep && (off_q || (!rc_mode && adon_q) || (eng_fin && !ie_q));
      end
   end

   always_ff @(posedge clk) begin
      if (eng_fin) res_q <= eng_res;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_CTRL: begin
            reg_rdata[B_FMT]             = fmt_q;
            reg_rdata[B_VREF]            = vref_q;
            reg_rdata[B_CHAN +: CHAN_W]  = chan_q;
            reg_rdata[B_GO]              = (state_q != ST_IDLE);
            reg_rdata[B_EN]              = adon_q;
         end
         ADR_CLK: begin
            reg_rdata[B_SEL +: SEL_W]    = sel_q;
            reg_rdata[B_AN +: NUM_AN]    = an_q;
         end
         ADR_RHI:  reg_rdata = res_hi;
         ADR_RLO:  reg_rdata = res_lo;
         ADR_FLAG: reg_rdata[B_DONE] = flag_q;
         ADR_IEN:  reg_rdata[B_DONE] = ie_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign chan_sel   = chan_q;
   assign ref_sel    = vref_q;
   assign pin_analog = an_q;
   assign analog_on  = adon_q && !off_q;
   assign wake_req   = wake_q;

   a_r5_fin_clears_go: assert property (@(posedge clk) disable iff (!rst_n)
      eng_fin |=> (state_q == ST_IDLE));
   a_r5_fin_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      eng_fin |=> flag_q);
   a_r9_sleep_stops: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_off |=> !eng_busy);
   a_r8_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> ($past(ie_q) && $past(sleep)));
   a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !adon_q |-> !eng_busy);
endmodule

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       instr_tick = 1'b0, rc_tick = 1'b0, sleep = 1'b0;
   logic       cmp_in;
   logic [9:0] dac_code;
   logic [1:0] chan_sel;
   logic       ref_sel, analog_on, wake_req;
   logic [3:0] pin_analog;

   logic [9:0] vin = 10'd0;
   logic       rc_run = 1'b0, instr_run = 1'b0, instr_force = 1'b0;
   int         tcnt = 0, wake_cnt = 0;
   int         total = 0, bad = 0;

   always #5 clk = ~clk;

   assign cmp_in = (vin >= dac_code);

   sar_conv_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .instr_tick(instr_tick),
      .rc_tick(rc_tick), .sleep(sleep), .cmp_in(cmp_in), .dac_code(dac_code),
      .chan_sel(chan_sel), .ref_sel(ref_sel), .pin_analog(pin_analog),
      .analog_on(analog_on), .wake_req(wake_req)
   );

   always @(negedge clk) begin
      tcnt = tcnt + 1;
      rc_tick    = rc_run && (tcnt % 3 == 0);
      instr_tick = instr_run ? (tcnt % 5 == 0) : instr_force;
      if (wake_req) wake_cnt = wake_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(output int cycles);
      logic [7:0] c;
      cycles = 0;
      rd(3'd0, c);
      while (c[1] && cycles < 3000) begin
         @(negedge clk);
         cycles++;
         rd(3'd0, c);
      end
   endtask

   function automatic logic [15:0] layout(input logic [9:0] r, input logic right);
      if (right) return {6'b0, r[9:8], r[7:0]};
      return {r[9:2], r[1:0], 6'b0};
   endfunction

   localparam int NV = 8;
   localparam logic [13:0] VEC [NV] = '{
      {10'h000, 1'b0, 3'd0}, {10'h3FF, 1'b1, 3'd0}, {10'h200, 1'b0, 3'd2},
      {10'h1FF, 1'b1, 3'd1}, {10'h2AA, 1'b0, 3'd6}, {10'h155, 1'b1, 3'd7},
      {10'h003, 1'b1, 3'd3}, {10'h3FC, 1'b0, 3'd5}
   };

   initial begin
      #(150000 * 10);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0]  d, hi, lo;
      logic [15:0] e;
      logic [9:0]  last;
      int          cyc, w0;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
      rd(3'd1, d); chk("R1 clk reg", d, 8'h0F);
      rd(3'd4, d); chk("R1 flag", d, 8'h00);
      rd(3'd5, d); chk("R1 ien", d, 8'h00);
      chk("R1 wake", wake_req, 1'b0);
      chk("R1 analog_on", analog_on, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R5 R6 vector walk
      for (int i = 0; i < NV; i++) begin
         vin = VEC[i][13:4];
         rc_run = 1'b1; instr_run = 1'b1;
         wr(3'd1, {1'b0, VEC[i][2:0], 4'hF});
         wr(3'd0, {VEC[i][3], 7'b000_0111});
         wait_idle(cyc);
         rd(3'd2, hi); rd(3'd3, lo);
         e = layout(vin, VEC[i][3]);
         chk("R2 R3 result hi", hi, e[15:8]);
         chk("R2 R3 result lo", lo, e[7:0]);
         rd(3'd4, d); chk("R5 flag set", d, 8'h40);
         chk("R4 chan_sel", chan_sel, 2'd1);
         wr(3'd4, 8'h00);
         rd(3'd4, d); chk("R5 flag cleared", d, 8'h00);
      end
      last = 10'h3FC;

      // R6 divided-clock duration
      rc_run = 1'b0; instr_run = 1'b0;
      vin = 10'h123;
      wr(3'd1, 8'h0F);
      wr(3'd0, 8'h03);
      wait_idle(cyc);
      chk_rng("R6 div2 duration", cyc, 18, 22);
      wr(3'd1, 8'h5F);
      wr(3'd0, 8'h03);
      @(negedge clk);
      chk("R2 first trial code", dac_code, 10'h200);
      wait_idle(cyc);
      chk_rng("R6 div64 duration", cyc, 575, 642);
      rd(3'd2, hi); chk("R6 result at div64", hi, 8'h48);
      last = 10'h123;
      wr(3'd4, 8'h00);

      // R7 RC start waits for instruction strobe
      vin = 10'h2C1;
      rc_run = 1'b1; instr_run = 1'b0;
      wr(3'd1, 8'h6F);
      wr(3'd0, 8'h83);
      repeat (60) @(negedge clk);
      rd(3'd0, d); chk("R7 held without strobe", d[1], 1'b1);
      rd(3'd4, d); chk("R7 no flag while held", d, 8'h00);
      @(posedge clk); instr_force = 1'b1;
      @(posedge clk); #1 instr_force = 1'b0;
      wait_idle(cyc);
      chk_rng("R7 ten rc ticks", cyc, 26, 32);
      rd(3'd3, lo); chk("R7 result", lo, 8'hC1);
      last = 10'h2C1;
      wr(3'd4, 8'h00);

      // R8 RC conversion through sleep, interrupt enabled
      wr(3'd5, 8'h40);
      vin = 10'h0F0;
      instr_run = 1'b1;
      w0 = wake_cnt;
      wr(3'd0, 8'h83);
      repeat (8) @(negedge clk);
      instr_run = 1'b0; sleep = 1'b1;
      wait_idle(cyc);
      repeat (2) @(negedge clk);
      chk("R8 one wake pulse", wake_cnt - w0, 1);
      rd(3'd4, d); chk("R8 flag in sleep", d, 8'h40);
      chk("R8 analog stays on", analog_on, 1'b1);
      rd(3'd3, lo); chk("R8 result", lo, 8'hF0);
      sleep = 1'b0;
      wr(3'd4, 8'h00);

      // R8 interrupt disabled: module off, enable bit kept
      wr(3'd5, 8'h00);
      vin = 10'h301;
      instr_run = 1'b1;
      w0 = wake_cnt;
      wr(3'd0, 8'h83);
      repeat (8) @(negedge clk);
      instr_run = 1'b0; sleep = 1'b1;
      wait_idle(cyc);
      repeat (2) @(negedge clk);
      chk("R8 no wake", wake_cnt - w0, 0);
      chk("R8 analog off", analog_on, 1'b0);
      rd(3'd0, d); chk("R8 enable kept", d[0], 1'b1);
      sleep = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R8 analog back", analog_on, 1'b1);
      last = 10'h301;
      wr(3'd4, 8'h00);

      // R9 sleep aborts divided-clock conversion
      rc_run = 1'b0;
      wr(3'd1, 8'h5F);
      vin = 10'h055;
      wr(3'd0, 8'h03);
      repeat (100) @(negedge clk);
      rd(3'd0, d); chk("R9 busy before sleep", d[1], 1'b1);
      sleep = 1'b1;
      repeat (2) @(negedge clk);
      rd(3'd0, d); chk("R9 go cleared", d, 8'h01);
      chk("R9 analog off", analog_on, 1'b0);
      repeat (800) @(negedge clk);
      rd(3'd4, d); chk("R9 no flag", d, 8'h00);
      e = layout(last, 1'b0);
      rd(3'd2, hi); chk("R9 result hi kept", hi, e[15:8]);
      rd(3'd3, lo); chk("R9 result lo kept", lo, e[7:0]);
      sleep = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 analog back", analog_on, 1'b1);

      // R10 start with enable clear has no effect
      wr(3'd1, 8'h0F);
      wr(3'd0, 8'h02);
      rd(3'd0, d); chk("R10 go ignored", d, 8'h00);
      repeat (200) @(negedge clk);
      rd(3'd4, d); chk("R10 no flag", d, 8'h00);
      rd(3'd2, hi); chk("R10 result kept", hi, e[15:8]);

      // R4 R12 field layout
      wr(3'd0, 8'h7C);
      rd(3'd0, d); chk("R4 bits 5:4 read zero", d, 8'h4C);
      chk("R4 chan_sel", chan_sel, 2'd3);
      chk("R4 ref_sel", ref_sel, 1'b1);
      wr(3'd1, 8'h3A);
      rd(3'd1, d); chk("R12 clk reg readback", d, 8'h3A);
      chk("R12 pin_analog", pin_analog, 4'hA);

      // R11 reset mid-conversion keeps result
      wr(3'd1, 8'h5F);
      vin = 10'h3AB;
      wr(3'd0, 8'h03);
      repeat (50) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (700) @(negedge clk);
      rd(3'd0, d); chk("R11 ctrl reset", d, 8'h00);
      rd(3'd1, d); chk("R11 clk reg reset", d, 8'h0F);
      rd(3'd4, d); chk("R11 no flag", d, 8'h00);
      rd(3'd2, hi); chk("R11 result hi kept", hi, e[15:8]);
      rd(3'd3, lo); chk("R11 result lo kept", lo, e[7:0]);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule